// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake side of an eight-bit parallel peripheral port. A three-bit mode field picks one of four behaviours: plain unhandshaked I/O, strobed input, strobed output, and strobed output in which the port pins float except while the peripheral acknowledges. One external active-low line serves as the peripheral's strobe in input mode and as its acknowledge in the output modes. The block drives a buffer-full pin toward the peripheral and an interrupt line toward the CPU.

The block does no address decoding. A register front end passes it single-cycle events: the mode register was written, a byte read of the port finished, a byte write of the port finished, and a single-bit write hit the buffer-full pin. It also passes the current interrupt-enable latch, the port's direction bits and its output latch. The handshake line passes through a synchroniser, and its falling (leading) and rising (trailing) edges are detected in the clock domain. A change on the pin is seen in the flags on the third rising clock edge after it.

Top module: `hs_port_ctrl`

## Requirements
- R1: A mode write loads the mode from mode_sel (bit 2 = float control, bit 1 = direction, bit 0 = strobed; 0 in bit 0 = basic, 001 = strobed input, 011 = strobed output, 111 = floating output). Strobed input starts with buffer-full and interrupt request low. The output modes start with buffer-full_pin high and interrupt request equal to irq_en. Basic mode clears both.
- R2: In strobed input mode the leading (falling) edge of hs_strobe_n drives buf_full_pin high.
- R3: In strobed input mode the trailing (rising) edge of hs_strobe_n captures pa_pins_in into the value shown on pa_rd_data and sets the interrupt request. That value then stays fixed while the pins change.
- R4: In strobed input mode a completed port byte read clears buffer-full and interrupt request. A completed port byte write leaves both unchanged.
- R5: In the output modes a completed port byte write drives buf_full_pin low and clears the interrupt request.
- R6: In the output modes the leading edge of the acknowledge drives buf_full_pin high. Its trailing edge sets the interrupt request.
- R7: intr is the interrupt request gated by irq_en. irq_poll shows the ungated request for polling.
- R8: pa_oe equals pa_dir in every mode except floating output. In floating output it equals pa_dir only while the synchronised acknowledge is low, and is all zero otherwise.
- R9: In basic mode intr stays low, buf_full_pin is low, and handshake edges and byte accesses leave irq_poll unchanged.
- R10: A bit write to the buffer-full pin in a strobed mode sets buf_full_pin to pb6_bit_val.
- R11: After reset the mode is basic, and intr, irq_poll, buf_full_pin and pa_oe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | One-cycle pulse: mode register written |
| mode_sel | input | 3 | Mode byte bits 7..5 (float, direction, strobed) |
| irq_en | input | 1 | Interrupt enable (port B bit 7 output latch) |
| pa_byte_rd_done | input | 1 | Pulse: trailing edge of a port byte read |
| pa_byte_wr_done | input | 1 | Pulse: trailing edge of a port byte write |
| pb6_bit_wr | input | 1 | Pulse: bit set/clear aimed at the buffer-full pin |
| pb6_bit_val | input | 1 | Value of that bit set/clear |
| hs_strobe_n | input | 1 | Asynchronous strobe / acknowledge from peripheral |
| pa_dir | input | 8 | Port direction bits, 1 = output |
| pa_out_latch | input | 8 | Port output data latch |
| pa_pins_in | input | 8 | Port pin levels |
| pa_oe | output | 8 | Per-pin output enable |
| pa_pins_out | output | 8 | Data driven onto enabled pins |
| pa_rd_data | output | 8 | Value a port byte read returns |
| buf_full_pin | output | 1 | Buffer-full line to the peripheral |
| intr | output | 1 | Interrupt request to the CPU |
| irq_poll | output | 1 | Ungated interrupt request for polling |

## Verification
A wrong flag shows up at buf_full_pin or irq_poll three clock edges after the handshake pin moves, or one edge after a byte-access pulse. So a missed or reversed edge detection appears within a few cycles of each stimulus. A corrupted capture shows on pa_rd_data only once the pins change after the trailing strobe. The bench therefore moves the pins after every capture. A wrong floating-output enable is seen on pa_oe on both sides of the acknowledge pulse.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    HM_BASIC = 2'd0,
    HM_SIN   = 2'd1,
    HM_SOUT  = 2'd2,
    HM_STRI  = 2'd3
  } hs_mode_t;

  // mode_sel = {float, direction, strobed}
  function automatic hs_mode_t decode_mode(input logic [2:0] sel);
    hs_mode_t m;
    if (!sel[0])      m = HM_BASIC;
    else if (!sel[1]) m = HM_SIN;
    else if (!sel[2]) m = HM_SOUT;
    else              m = HM_STRI;
    return m;
  endfunction

  function automatic logic is_out_mode(input hs_mode_t m);
    return (m == HM_SOUT) || (m == HM_STRI);
  endfunction

  // Buffer-full pin: active high in input mode, active low in output modes
  function automatic logic full_to_pin(input hs_mode_t m, input logic full);
    logic p;
    case (m)
      HM_SIN:  p = full;
      HM_SOUT: p = ~full;
      HM_STRI: p = ~full;
      default: p = 1'b0;
    endcase
    return p;
  endfunction

  // Inverse of full_to_pin, used by the pin override
  function automatic logic pin_to_full(input hs_mode_t m, input logic pin);
    return (m == HM_SIN) ? pin : ~pin;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic level,
  output logic fell,
  output logic rose
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[LAST];
  end

  assign level = chain[LAST];
  assign fell  = prev & ~chain[LAST];
  assign rose  = ~prev & chain[LAST];

  assert_one_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell);

endmodule

// File: rtl/hs_flags.sv
module hs_flags
  import hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_wr,
  input  logic [2:0] mode_sel,
  input  logic     irq_en,
  input  logic     rd_done,
  input  logic     wr_done,
  input  logic     pb6_wr,
  input  logic     pb6_val,
  input  logic     lead_ev,
  input  logic     trail_ev,
  output hs_mode_t mode,
  output logic     full,
  output logic     irq
);

  hs_mode_t next_mode;
  assign next_mode = decode_mode(mode_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= HM_BASIC;
      full <= 1'b0;
      irq  <= 1'b0;
    end else if (mode_wr) begin
      mode <= next_mode;
      full <= 1'b0;
      irq  <= is_out_mode(next_mode) ? irq_en : 1'b0;
    end else begin
      case (mode)
        HM_SIN: begin
          if (rd_done)  begin full <= 1'b0; irq <= 1'b0; end
          if (lead_ev)  full <= 1'b1;
          if (trail_ev) irq  <= 1'b1;
        end
        HM_SOUT, HM_STRI: begin
          if (lead_ev)  full <= 1'b0;
          if (wr_done)  begin full <= 1'b1; irq <= 1'b0; end
          if (trail_ev) irq  <= 1'b1;
        end
        default: ;
      endcase
      if (pb6_wr && (mode != HM_BASIC)) full <= pin_to_full(mode, pb6_val);
    end
  end

  assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_SIN && rd_done && !lead_ev && !trail_ev && !pb6_wr && !mode_wr)
      |=> (!full && !irq));

  assert_wr_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out_mode(mode) && wr_done && !trail_ev && !pb6_wr && !mode_wr)
      |=> (full && !irq));

  assert_trail_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != HM_BASIC && trail_ev && !mode_wr) |=> irq);

  assert_basic_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_BASIC && !mode_wr) |=> $stable(irq));

endmodule

// File: rtl/hs_porta.sv
module hs_porta
  import hs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hs_mode_t         mode,
  input  logic             trail_ev,
  input  logic             ack_level_n,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] out_latch,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] pins_out,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] cap;
  logic             capture;

  assign capture = (mode == HM_SIN) && trail_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap <= '0;
    else if (capture) cap <= pins_in;
  end

  always_comb begin
    oe = dir;
    if (mode == HM_STRI && ack_level_n) oe = '0;
  end

  assign pins_out = out_latch;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_rd
      assign rd_data[b] = (mode == HM_SIN) ? cap[b]
                        : (dir[b] ? out_latch[b] : pins_in[b]);
    end
  endgenerate

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (cap == $past(pins_in)));

  assert_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_STRI && ack_level_n) |-> (oe == '0));

endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             irq_en,
  input  logic             pa_byte_rd_done,
  input  logic             pa_byte_wr_done,
  input  logic             pb6_bit_wr,
  input  logic             pb6_bit_val,
  input  logic             hs_strobe_n,
  input  logic [WIDTH-1:0] pa_dir,
  input  logic [WIDTH-1:0] pa_out_latch,
  input  logic [WIDTH-1:0] pa_pins_in,
  output logic [WIDTH-1:0] pa_oe,
  output logic [WIDTH-1:0] pa_pins_out,
  output logic [WIDTH-1:0] pa_rd_data,
  output logic             buf_full_pin,
  output logic             intr,
  output logic             irq_poll
);

  logic     hs_level_n;
  logic     lead_ev;
  logic     trail_ev;
  hs_mode_t mode;
  logic     full;
  logic     irq;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (hs_strobe_n),
    .level   (hs_level_n),
    .fell    (lead_ev),
    .rose    (trail_ev)
  );

  hs_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_sel (mode_sel),
    .irq_en   (irq_en),
    .rd_done  (pa_byte_rd_done),
    .wr_done  (pa_byte_wr_done),
    .pb6_wr   (pb6_bit_wr),
    .pb6_val  (pb6_bit_val),
    .lead_ev  (lead_ev),
    .trail_ev (trail_ev),
    .mode     (mode),
    .full     (full),
    .irq      (irq)
  );

  hs_porta #(.WIDTH(WIDTH)) u_porta (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .trail_ev    (trail_ev),
    .ack_level_n (hs_level_n),
    .dir         (pa_dir),
    .out_latch   (pa_out_latch),
    .pins_in     (pa_pins_in),
    .oe          (pa_oe),
    .pins_out    (pa_pins_out),
    .rd_data     (pa_rd_data)
  );

  assign buf_full_pin = full_to_pin(mode, full);
  assign irq_poll     = irq;
  assign intr         = irq & irq_en & (mode != HM_BASIC);

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !intr);

  assert_basic_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_BASIC) |-> (!intr && !buf_full_pin));

  assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pb6_bit_wr && !mode_wr && mode != HM_BASIC) |=> (buf_full_pin == $past(pb6_bit_val)));

endmodule

// File: tb/hs_port_ctrl_tb_top.sv
module hs_port_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       irq_en = 1'b0;
  logic       rd_done = 1'b0;
  logic       wr_done = 1'b0;
  logic       pb6_wr = 1'b0;
  logic       pb6_val = 1'b0;
  logic       strobe_n = 1'b1;
  logic [7:0] dir = 8'h00;
  logic [7:0] olatch = 8'h00;
  logic [7:0] pins = 8'h00;
  logic [7:0] oe, pout, rd;
  logic       bfp, intr, poll;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic       intr;
    logic       bfp;
    logic       poll;
    logic [7:0] oe;
    logic [7:0] rd;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  hs_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .irq_en(irq_en), .pa_byte_rd_done(rd_done), .pa_byte_wr_done(wr_done),
    .pb6_bit_wr(pb6_wr), .pb6_bit_val(pb6_val), .hs_strobe_n(strobe_n),
    .pa_dir(dir), .pa_out_latch(olatch), .pa_pins_in(pins),
    .pa_oe(oe), .pa_pins_out(pout), .pa_rd_data(rd),
    .buf_full_pin(bfp), .intr(intr), .irq_poll(poll)
  );

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (intr !== e.intr || bfp !== e.bfp || poll !== e.poll ||
            oe !== e.oe || rd !== e.rd) begin
          errors++;
          $display("FAIL %s: got intr=%b bfp=%b poll=%b oe=%h rd=%h exp intr=%b bfp=%b poll=%b oe=%h rd=%h",
                   e.req, intr, bfp, poll, oe, rd, e.intr, e.bfp, e.poll, e.oe, e.rd);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic expect_st(input string req, input logic ei, input logic eb,
                           input logic ep, input logic [7:0] eo, input logic [7:0] er);
    exp_t e;
    e.req = req; e.intr = ei; e.bfp = eb; e.poll = ep; e.oe = eo; e.rd = er;
    q.push_back(e);
    step(1);
  endtask

  task automatic set_mode(input logic [2:0] s);
    mode_sel = s; mode_wr = 1'b1; step(1); mode_wr = 1'b0; step(1);
  endtask

  task automatic pulse_rd;  rd_done = 1'b1; step(1); rd_done = 1'b0; step(1); endtask
  task automatic pulse_wr;  wr_done = 1'b1; step(1); wr_done = 1'b0; step(1); endtask
  task automatic pulse_pb6(input logic v);
    pb6_val = v; pb6_wr = 1'b1; step(1); pb6_wr = 1'b0; step(1);
  endtask
  task automatic hs_pin(input logic v); strobe_n = v; step(4); endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    pins = 8'h3C;
    step(1);
    expect_st("R11 reset", 0, 0, 0, 8'h00, 8'h3C);

    // basic mode: strobes and accesses ignored
    irq_en = 1'b1;
    hs_pin(1'b0); hs_pin(1'b1); pulse_rd(); pulse_wr();
    expect_st("R9 basic quiet", 0, 0, 0, 8'h00, 8'h3C);

    // strobed input
    set_mode(3'b001);
    expect_st("R1 input init", 0, 0, 0, 8'h00, 8'h00);
    pins = 8'h5A;
    hs_pin(1'b0);
    expect_st("R2 leading edge full", 0, 1, 0, 8'h00, 8'h00);
    hs_pin(1'b1);
    expect_st("R3 trailing capture irq", 1, 1, 1, 8'h00, 8'h5A);
    pins = 8'h11; step(1);
    expect_st("R3 capture held", 1, 1, 1, 8'h00, 8'h5A);
    pulse_wr();
    expect_st("R4 byte write ignored", 1, 1, 1, 8'h00, 8'h5A);
    pulse_rd();
    expect_st("R4 byte read clears", 0, 0, 0, 8'h00, 8'h5A);
    irq_en = 1'b0;
    hs_pin(1'b0); hs_pin(1'b1);
    expect_st("R7 gated poll", 0, 1, 1, 8'h00, 8'h11);
    pulse_pb6(1'b0);
    expect_st("R10 override input", 0, 0, 1, 8'h00, 8'h11);

    // strobed output
    irq_en = 1'b1; dir = 8'hFF; olatch = 8'hC3;
    set_mode(3'b011);
    expect_st("R1 output init", 1, 1, 1, 8'hFF, 8'hC3);
    pulse_wr();
    expect_st("R5 byte write", 0, 0, 0, 8'hFF, 8'hC3);
    hs_pin(1'b0);
    expect_st("R6 ack leading", 0, 1, 0, 8'hFF, 8'hC3);
    hs_pin(1'b1);
    expect_st("R6 ack trailing", 1, 1, 1, 8'hFF, 8'hC3);
    dir = 8'h0F; step(1);
    expect_st("R8 plain output oe", 1, 1, 1, 8'h0F, 8'h13);
    dir = 8'hFF;

    // floating output, enable off
    irq_en = 1'b0;
    set_mode(3'b111);
    expect_st("R1 float init no enable", 0, 1, 0, 8'h00, 8'hC3);
    pulse_wr();
    expect_st("R5 float write", 0, 0, 0, 8'h00, 8'hC3);
    hs_pin(1'b0);
    expect_st("R8 ack low drives", 0, 1, 0, 8'hFF, 8'hC3);
    hs_pin(1'b1);
    expect_st("R8 ack high floats", 0, 1, 1, 8'h00, 8'hC3);
    irq_en = 1'b1; step(1);
    expect_st("R7 enable reveals", 1, 1, 1, 8'h00, 8'hC3);
    pulse_pb6(1'b0);
    expect_st("R10 override output", 1, 0, 1, 8'h00, 8'hC3);

    set_mode(3'b000);
    expect_st("R9 back to basic", 0, 0, 0, 8'hFF, 8'hC3);
    step(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule